// File: doc/BRIEF.md
# Double-Buffered TDM Routing Table Swap Controller

This block keeps the bookkeeping for a routing memory that serves two time-division multiplexed channels. Each channel has a receive table and a transmit table, giving four tables in all. Every table is split into two halves. The active half steers the current frames. The other half is a shadow that software can rewrite with a new routing. Software arms a swap for one table by writing a 1 to that table's bit in a command register. The controller then exchanges the halves at that table's next frame-sync pulse and drops the arm bit by itself. Software polls the arm bit to learn when the swap has finished.

A read-only status register reports which half of each table is live. Next to it, the block drives a memory base address for each table. That address depends on the live half and on a routing-mode input. In one mode each half holds 128 entries. In the split mode each half holds 64 entries, so both channels fit in the same memory. The base addresses are registered and change on the same clock edge as the status bit. As a result, no frame is steered by a mix of old and new halves.

Top module: `tdm_route_swap`

## Requirements
- R1: The command register is at `host_sel`=0. Bit 0 arms receive channel A, bit 1 arms transmit channel A, bit 2 arms receive channel B and bit 3 arms transmit channel B. A write of 1 to one of these bits sets it. Reads return the pending bits in bits 3:0, and bits 7:4 always read 0.
- R2: Writing 0 to a pending command bit does not clear it, and writing 1 to a pending bit leaves it set. Only the controller clears a pending bit.
- R3: A swap happens only on a clock edge where `fsync[i]` is high and command bit i is already set. On that edge status bit i toggles and command bit i clears. On the same edge a write of 1 to bit i is absorbed, so the bit still ends clear. A sync pulse with no pending bit, or a write that sets the bit on the sync edge, causes no swap.
- R4: The status register is at `host_sel`=1 and is read-only. Its bits 3:0 use the same table order as the command register. A host write to it changes neither the status nor the command bits, and its bits 7:4 read 0.
- R5: `host_rvalid` arrives with each read. For a status read, bit i is 0 while command bit i is pending and 1 otherwise. For a command read it is all ones.
- R6: With `route_mode`=2'b01, a receive table's base is 0 when its status is 0 and 128 when it is 1. A transmit table's base is 256 or 384. Channel B uses the same regions as channel A.
- R7: With `route_mode`=2'b11, receive A bases are 0 or 64, transmit A bases are 256 or 320, receive B bases are 128 or 192, and transmit B bases are 384 or 448.
- R8: The route_mode encodings 2'b00 and 2'b10 produce the same addresses as 2'b01.
- R9: After synchronous reset, all command and status bits are 0 and every base points at its lower half.
- R10: `host_rdata` and `host_rvalid` appear one clock after `host_sel` is applied. `base_addr` changes on the same edge as the status bit it follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the selected register |
| host_sel | input | 1 | Register select: 0 command, 1 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data of the selected register |
| host_rvalid | output | 4 | Per-table validity of the read data |
| fsync | input | 4 | Frame-sync pulse per table (rxA, txA, rxB, txB) |
| route_mode | input | 2 | Routing mode that sets half size and channel split |
| base_addr | output | 36 | Four 9-bit live-half base addresses, table i at bits [9i+8:9i] |

## Verification
The bench arms swaps and then sends sync pulses to the wrong table. A controller that reacted to any pulse would flip status bits that should hold. It writes zeros over pending bits and writes into the read-only status register. A block that let software cancel a swap or force a half would show altered bits on readback. It arms all four tables at once and retires them one sync at a time in a shuffled order. A shared or mis-indexed completion path would clear the wrong bit or several bits together. It also covers four edge cases. First, it reads status while swaps are pending and expects the validity mask to drop. Second, it walks the bases through every routing mode, where a wrong half size or channel offset shows up as a bad address. Third, it puts a write of 1 on the sync edge, where a design that let the write win would leave a stale bit set. Fourth, it samples the base address on the swap edge itself, where a design with a lagging base would show the old address for one cycle.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int NTAB   = 4;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;

  localparam logic [1:0] MODE_SPLIT = 2'b11;

  // Base of the live half for one table.
  // tab[0] = direction (1 = transmit), tab[1] = channel (1 = B).
  function automatic logic [ADDR_W-1:0] live_base(
    input logic [1:0] tab,
    input logic       half,
    input logic [1:0] mode
  );
    localparam int DIR_SPAN   = 2 ** (ADDR_W - 1);
    localparam int FULL_HALF  = 2 ** (ADDR_W - 2);
    localparam int SPLIT_HALF = 2 ** (ADDR_W - 3);
    logic [ADDR_W-1:0] b;
    b = '0;
    if (tab[0]) b = b + ADDR_W'(DIR_SPAN);
    if (mode == MODE_SPLIT) begin
      if (tab[1]) b = b + ADDR_W'(FULL_HALF);
      if (half)   b = b + ADDR_W'(SPLIT_HALF);
    end else begin
      if (half)   b = b + ADDR_W'(FULL_HALF);
    end
    return b;
  endfunction
endpackage

// File: rtl/trs_swap_lane.sv
module trs_swap_lane (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic fsync,
  output logic req_q,
  output logic stat_q,
  output logic stat_next
);
  logic swap;
  logic req_d;

  always_comb begin
    swap      = req_q & fsync;
    req_d     = swap ? 1'b0 : (req_q | set_req);
    stat_next = stat_q ^ swap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      stat_q <= stat_next;
    end
  end

  // R3: a pending swap retires on its sync edge, and the half flips
  p_swap_done_r3: assert property (@(posedge clk) disable iff (rst)
    (req_q && fsync) |=> (!req_q && (stat_q != $past(stat_q))));

  // R3: no swap means the half holds
  p_half_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(req_q && fsync) |=> (stat_q == $past(stat_q)));

  // R2: a pending bit stays set until its sync arrives
  p_req_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (req_q && !fsync) |=> req_q);
endmodule

// File: rtl/trs_base_gen.sv
module trs_base_gen
  import trs_pkg::*;
#(
  parameter logic [1:0] TAB = 2'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              stat_next,
  input  logic              stat_q,
  output logic [ADDR_W-1:0] base_q
);
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= live_base(TAB, 1'b0, mode);
      mode_q <= mode;
    end else begin
      base_q <= live_base(TAB, stat_next, mode);
      mode_q <= mode;
    end
  end

  // R10: a half flip under a steady mode moves the base on the same edge
  p_base_moves_r10: assert property (@(posedge clk) disable iff (rst)
    ((stat_q != $past(stat_q)) && (mode_q == $past(mode_q)))
      |-> (base_q != $past(base_q)));

  // R6: receive tables stay below the transmit region, transmit tables above
  p_base_region_r6: assert property (@(posedge clk) disable iff (rst)
    base_q[ADDR_W-1] == TAB[0]);
endmodule

// File: rtl/trs_host_port.sv
module trs_host_port
  import trs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [NTAB-1:0]   req,
  input  logic [NTAB-1:0]   stat,
  output logic [DATA_W-1:0] rdata_q,
  output logic [NTAB-1:0]   rvalid_q
);
  localparam int PAD_W = DATA_W - NTAB;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= '1;
    end else if (sel) begin
      rdata_q  <= {{PAD_W{1'b0}}, stat};
      rvalid_q <= ~req;
    end else begin
      rdata_q  <= {{PAD_W{1'b0}}, req};
      rvalid_q <= '1;
    end
  end
endmodule

// File: rtl/tdm_route_swap.sv
module tdm_route_swap
  import trs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic                   host_sel,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  output logic [NTAB-1:0]        host_rvalid,
  input  logic [NTAB-1:0]        fsync,
  input  logic [1:0]             route_mode,
  output logic [NTAB*ADDR_W-1:0] base_addr
);
  logic [NTAB-1:0] set_req;
  logic [NTAB-1:0] req_vec;
  logic [NTAB-1:0] stat_vec;
  logic [NTAB-1:0] stat_nxt;

  always_comb begin
    set_req = (host_wr && !host_sel) ? host_wdata[NTAB-1:0] : '0;
  end

  for (genvar i = 0; i < NTAB; i++) begin : g_tab
    trs_swap_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .set_req   (set_req[i]),
      .fsync     (fsync[i]),
      .req_q     (req_vec[i]),
      .stat_q    (stat_vec[i]),
      .stat_next (stat_nxt[i])
    );

    trs_base_gen #(.TAB(2'(i))) u_base (
      .clk       (clk),
      .rst       (rst),
      .mode      (route_mode),
      .stat_next (stat_nxt[i]),
      .stat_q    (stat_vec[i]),
      .base_q    (base_addr[i*ADDR_W +: ADDR_W])
    );
  end

  trs_host_port u_host (
    .clk      (clk),
    .rst      (rst),
    .sel      (host_sel),
    .req      (req_vec),
    .stat     (stat_vec),
    .rdata_q  (host_rdata),
    .rvalid_q (host_rvalid)
  );

  // R4: writes aimed at the status register never disturb the tables
  p_stat_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel && (fsync == '0))
      |=> ((req_vec == $past(req_vec)) && (stat_vec == $past(stat_vec))));

  // R9: reset leaves every table idle in its lower half
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> ((req_vec == '0) && (stat_vec == '0)));

  // R5: a status read flags every pending table as not valid
  p_mask_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (host_sel && (fsync == '0) && !host_wr)
      |=> ((host_rvalid & req_vec) == '0));
endmodule

// File: tb/tdm_route_swap_tb.sv
`timescale 1ns/1ps
module tdm_route_swap_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic [3:0]  host_rvalid;
  logic [3:0]  fsync = 4'h0;
  logic [1:0]  route_mode = 2'b01;
  logic [35:0] base_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_route_swap dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .fsync(fsync), .route_mode(route_mode), .base_addr(base_addr)
  );

  // {wr, wdata[3:0], fsync[3:0], mode[1:0], exp_req[3:0], exp_stat[3:0]}
  localparam int NV = 14;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 4'b0001, 4'b0000, 2'b01, 4'b0001, 4'b0000}, // R1 arm rxA
    {1'b0, 4'b0000, 4'b0010, 2'b01, 4'b0001, 4'b0000}, // R3 sync on other table
    {1'b0, 4'b0000, 4'b0001, 2'b01, 4'b0000, 4'b0001}, // R3 swap rxA, R6
    {1'b1, 4'b0010, 4'b0000, 2'b01, 4'b0010, 4'b0001}, // R1 arm txA
    {1'b1, 4'b0000, 4'b0000, 2'b01, 4'b0010, 4'b0001}, // R2 write 0
    {1'b1, 4'b0010, 4'b0000, 2'b01, 4'b0010, 4'b0001}, // R2 write 1 again
    {1'b0, 4'b0000, 4'b0010, 2'b01, 4'b0000, 4'b0011}, // R3 swap txA, R6
    {1'b1, 4'b1111, 4'b0000, 2'b11, 4'b1111, 4'b0011}, // R1 arm all, R7
    {1'b0, 4'b0000, 4'b0100, 2'b11, 4'b1011, 4'b0111}, // R3 rxB alone
    {1'b0, 4'b0000, 4'b1000, 2'b11, 4'b0011, 4'b1111}, // R3 txB alone
    {1'b0, 4'b0000, 4'b0001, 2'b11, 4'b0010, 4'b1110}, // R3 rxA alone
    {1'b0, 4'b0000, 4'b0010, 2'b11, 4'b0000, 4'b1100}, // R3 txA alone, R7
    {1'b1, 4'b0101, 4'b0000, 2'b10, 4'b0101, 4'b1100}, // R8 mode 10
    {1'b0, 4'b0000, 4'b0101, 2'b10, 4'b0000, 4'b1001}  // R8 two syncs together
  };

  function automatic logic [8:0] exp_base(int tab, logic s, logic [1:0] m);
    int v;
    v = (tab % 2) * 256;
    if (m == 2'b11) v = v + (tab / 2) * 128 + (s ? 64 : 0);
    else            v = v + (s ? 128 : 0);
    return 9'(v);
  endfunction

  task automatic chk(string rq, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_bases(string rq, logic [3:0] st, logic [1:0] m);
    for (int t = 0; t < 4; t++)
      chk(rq, 36'(base_addr[t*9 +: 9]), 36'(exp_base(t, st[t], m)));
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic step(logic wr, logic [3:0] wd, logic [3:0] fs, logic [1:0] m);
    host_sel   = 1'b0;
    host_wr    = wr;
    host_wdata = {4'h0, wd};
    fsync      = fs;
    route_mode = m;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    fsync   = 4'h0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d, output logic [3:0] mk);
    host_sel = sel;
    host_wr  = 1'b0;
    fsync    = 4'h0;
    @(posedge clk);
    @(negedge clk);
    d  = host_rdata;
    mk = host_rvalid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] mk;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk_bases("R9 reset bases", 4'b0000, 2'b01);
    rd(1'b0, d, mk); chk("R9 reset command", 36'(d), 36'h0);
    rd(1'b1, d, mk); chk("R9 reset status", 36'(d), 36'h0);

    // R4 status register ignores writes
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'hFF;
    @(posedge clk); @(negedge clk); host_wr = 1'b0;
    rd(1'b1, d, mk); chk("R4 status after write", 36'(d), 36'h0);
    rd(1'b0, d, mk); chk("R4 command after status write", 36'(d), 36'h0);

    // R1 reserved bits
    step(1'b1, 4'h0, 4'h0, 2'b01);
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = 8'hF0;
    @(posedge clk); @(negedge clk); host_wr = 1'b0;
    rd(1'b0, d, mk); chk("R1 reserved bits read zero", 36'(d), 36'h0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][18], VEC[v][17:14], VEC[v][13:10], VEC[v][9:8]);
      rd(1'b0, d, mk);
      chk($sformatf("R1/R2/R3 vector %0d command", v), 36'(d), 36'({4'h0, VEC[v][7:4]}));
      rd(1'b1, d, mk);
      chk($sformatf("R3/R4 vector %0d status", v), 36'(d), 36'({4'h0, VEC[v][3:0]}));
      chk_bases($sformatf("R6/R7/R8 vector %0d bases", v), VEC[v][3:0], VEC[v][9:8]);
    end

    // R5 validity mask while pending (stat 1001, mode 10)
    step(1'b1, 4'b0110, 4'h0, 2'b10);
    rd(1'b1, d, mk);
    chk("R5 status data while pending", 36'(d), 36'h09);
    chk("R5 mask while pending", 36'(mk), 36'b1001);
    rd(1'b0, d, mk); chk("R5 command read mask", 36'(mk), 36'hF);
    step(1'b0, 4'h0, 4'b0110, 2'b10);
    rd(1'b1, d, mk);
    chk("R5 mask after completion", 36'(mk), 36'hF);
    chk("R5 status after completion", 36'(d), 36'h0F);

    // R10 base moves on the swap edge (rxA 128 -> 0)
    step(1'b1, 4'b0001, 4'h0, 2'b10);
    chk("R10 rxA base before swap", 36'(base_addr[8:0]), 36'd128);
    fsync = 4'b0001;
    @(posedge clk); @(negedge clk);
    fsync = 4'h0;
    chk("R10 rxA base on swap edge", 36'(base_addr[8:0]), 36'd0);
    host_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10 read latency one cycle", 36'(host_rdata), 36'h0E);

    // R3 write coinciding with sync
    step(1'b1, 4'b0010, 4'b0010, 2'b10);
    rd(1'b0, d, mk); chk("R3 set on sync edge pends", 36'(d), 36'h02);
    rd(1'b1, d, mk); chk("R3 set on sync edge no swap", 36'(d), 36'h0E);
    step(1'b1, 4'b0010, 4'b0010, 2'b10);
    rd(1'b0, d, mk); chk("R3 completion beats write", 36'(d), 36'h00);
    rd(1'b1, d, mk); chk("R3 completion toggles", 36'(d), 36'h0C);

    // R9 reset mid-run with pending requests
    step(1'b1, 4'b1111, 4'h0, 2'b11);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk_bases("R9 bases after mid reset", 4'b0000, 2'b11);
    rd(1'b0, d, mk); chk("R9 command after mid reset", 36'(d), 36'h0);
    rd(1'b1, d, mk); chk("R9 status after mid reset", 36'(d), 36'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule